// File: doc/BRIEF.md
# Ethernet Pause Frame Classifier

This block sits behind a receive header parser. At the end of every frame it gets the destination address, source address, ethertype, opcode, a priority-enable vector and nine 16-bit pause time fields, all already extracted, together with a frame-end strobe and a flag saying whether the frame check sequence was good. It tests the frame against four independently programmable categories: global control (index 0), priority control (index 1), global pause (index 2) and priority pause (index 3).

Each category can require a destination address match against a programmed unicast and/or multicast address, a source address match, an ethertype match and an opcode match. The two control categories take an opcode inside an inclusive window. The two pause categories need one exact opcode. Pause hits become per-priority valid pulses with their time values. Control hits become a forward or drop decision. All results are registered and appear for one clock, one cycle after the strobe.

Top module: `pause_frame_classifier`

## Requirements
- R1: A category whose `cfg_cat_en` bit is 0 never sets its `cat_hit` bit, whatever the header holds.
- R2: With both address checks on, the DA passes if it equals either `cfg_ucast_da` or `cfg_mcast_da`. With one check on, it must equal that address. With neither on, any DA passes.
- R3: With the source check on, a category hits only when the SA equals `cfg_src_addr`.
- R4: With the ethertype check on, category k hits only when the ethertype equals slot k of `cfg_etype` (bits 16k+15:16k).
- R5: With the opcode check on, control category k (k = 0 or 1) accepts an opcode in the range min..max, both ends included. The bounds are slot k of `cfg_ctrl_op_min` and `cfg_ctrl_op_max`.
- R6: With the opcode check on, pause category k (k = 2 or 3) accepts only an opcode equal to slot k-2 of `cfg_pause_op`.
- R7: A priority pause hit sets `pause_vld[i]` = `hdr_prio_en[i]` for i = 0..7. Each such slot i of `pause_quanta` carries input quanta slot i.
- R8: A global pause hit sets `pause_vld[8]`, and `pause_quanta` slot 8 carries input quanta slot 8.
- R9: A control hit raises `ctrl_fwd` when `cfg_fwd_ctrl` is 1 and `ctrl_drop` when it is 0. The two are never both high.
- R10: A frame ending with `fcs_ok` = 0 yields no `cat_hit`, no `pause_vld` and no control decision.
- R11: Outputs are registered. They show the result only in the cycle after `frame_end` and are zero otherwise. A quanta slot whose valid bit is 0 reads 0.
- R12: When any pause category hits, `ctrl_fwd` and `ctrl_drop` stay 0 even if a control category also hits. Both `cat_hit` bits are still reported.
- R13: In and right after reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle strobe: header fields are valid |
| fcs_ok | input | 1 | Frame check sequence was good |
| hdr_da | input | 48 | Destination address |
| hdr_sa | input | 48 | Source address |
| hdr_etype | input | 16 | Ethertype |
| hdr_opcode | input | 16 | Control opcode |
| hdr_prio_en | input | 8 | Priority-enable vector of a priority pause frame |
| hdr_quanta | input | 144 | Nine 16-bit time fields, slot i at bits 16i+15:16i |
| cfg_ucast_da | input | 48 | Unicast address to compare |
| cfg_mcast_da | input | 48 | Multicast address to compare |
| cfg_src_addr | input | 48 | Source address to compare |
| cfg_cat_en | input | 4 | Category enables, bit k = category k |
| cfg_chk_mcast | input | 4 | Multicast DA check enables |
| cfg_chk_ucast | input | 4 | Unicast DA check enables |
| cfg_chk_sa | input | 4 | SA check enables |
| cfg_chk_etype | input | 4 | Ethertype check enables |
| cfg_chk_opcode | input | 4 | Opcode check enables |
| cfg_etype | input | 64 | Per-category ethertype, slot k |
| cfg_ctrl_op_min | input | 32 | Lower opcode bound, control categories 0 and 1 |
| cfg_ctrl_op_max | input | 32 | Upper opcode bound, control categories 0 and 1 |
| cfg_pause_op | input | 32 | Exact opcode, slot 0 for category 2, slot 1 for category 3 |
| cfg_fwd_ctrl | input | 1 | 1 forwards control frames, 0 drops them |
| cat_hit | output | 4 | Registered per-category match |
| pause_vld | output | 9 | Registered per-slot pause valid pulse |
| pause_quanta | output | 144 | Registered time values, zero where not valid |
| ctrl_fwd | output | 1 | Control frame to be forwarded |
| ctrl_drop | output | 1 | Control frame to be dropped |

## Verification
The block holds no state across frames, so any fault shows up in the single output cycle after the strobe, or as a non-zero output in a cycle where no strobe preceded it. A wrong comparison or enable term appears as a wrong `cat_hit` bit. A wrong slot mapping appears as a valid bit or time value in the wrong slot, or a non-zero time value beside a cleared valid bit. A broken priority or gating term appears as a control decision next to a pause hit, or as outputs after a bad-check frame. Every case is therefore observable one clock after the frame that provokes it.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int NUM_CAT = 4;

  typedef enum logic [1:0] {
    CAT_GCTRL  = 2'd0,
    CAT_PCTRL  = 2'd1,
    CAT_GPAUSE = 2'd2,
    CAT_PPAUSE = 2'd3
  } cat_e;

  // per-category check selection
  typedef struct packed {
    logic en;
    logic chk_mc;
    logic chk_uc;
    logic chk_sa;
    logic chk_et;
  } cat_chk_t;
endpackage

// File: rtl/pfc_cat_match.sv
module pfc_cat_match
  import pfc_pkg::*;
#(
  parameter int ADDR_W  = 48,
  parameter int FIELD_W = 16
) (
  input  cat_chk_t            chk,
  input  logic [ADDR_W-1:0]   da,
  input  logic [ADDR_W-1:0]   sa,
  input  logic [FIELD_W-1:0]  etype,
  input  logic [ADDR_W-1:0]   cfg_uc,
  input  logic [ADDR_W-1:0]   cfg_mc,
  input  logic [ADDR_W-1:0]   cfg_sa,
  input  logic [FIELD_W-1:0]  cfg_etype,
  input  logic                op_pass,
  output logic                hit
);
  // destination check: either enabled address may match; none enabled = open
  function automatic logic addr_check(input logic uc_on, input logic mc_on,
                                      input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] uc,
                                      input logic [ADDR_W-1:0] mc);
    return (!uc_on && !mc_on) || (uc_on && (a == uc)) || (mc_on && (a == mc));
  endfunction

  logic da_ok, sa_ok, et_ok;

  assign da_ok = addr_check(chk.chk_uc, chk.chk_mc, da, cfg_uc, cfg_mc);
  assign sa_ok = !chk.chk_sa || (sa == cfg_sa);
  assign et_ok = !chk.chk_et || (etype == cfg_etype);
  assign hit   = chk.en && da_ok && sa_ok && et_ok && op_pass;
endmodule

// File: rtl/pfc_out_stage.sv
module pfc_out_stage
  import pfc_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int NUM_PRIO = 8,
  localparam int NUM_SLOT = NUM_PRIO + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_end,
  input  logic                        fcs_ok,
  input  logic [NUM_CAT-1:0]          hit,
  input  logic [NUM_PRIO-1:0]         prio_en,
  input  logic [NUM_SLOT*FIELD_W-1:0] quanta_in,
  input  logic                        fwd_cfg,
  output logic [NUM_CAT-1:0]          cat_hit_q,
  output logic [NUM_SLOT-1:0]         vld_q,
  output logic [NUM_SLOT*FIELD_W-1:0] quanta_q,
  output logic                        fwd_q,
  output logic                        drop_q
);
  logic                        load;
  logic                        pause_any;
  logic                        ctrl_any;
  logic [NUM_CAT-1:0]          hit_d;
  logic [NUM_SLOT-1:0]         vld_d;
  logic [NUM_SLOT*FIELD_W-1:0] quanta_d;

  assign load      = frame_end && fcs_ok;
  assign hit_d     = load ? hit : '0;
  assign pause_any = hit_d[CAT_GPAUSE] || hit_d[CAT_PPAUSE];
  assign ctrl_any  = (hit_d[CAT_GCTRL] || hit_d[CAT_PCTRL]) && !pause_any;

  assign vld_d[NUM_PRIO-1:0] = hit_d[CAT_PPAUSE] ? prio_en : '0;
  assign vld_d[NUM_PRIO]     = hit_d[CAT_GPAUSE];

  for (genvar i = 0; i < NUM_SLOT; i++) begin : g_slot
    assign quanta_d[i*FIELD_W +: FIELD_W] =
      vld_d[i] ? quanta_in[i*FIELD_W +: FIELD_W] : '0;

    p_slot_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q[i] |-> (quanta_q[i*FIELD_W +: FIELD_W] == '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cat_hit_q <= '0;
      vld_q     <= '0;
      quanta_q  <= '0;
      fwd_q     <= 1'b0;
      drop_q    <= 1'b0;
    end else begin
      cat_hit_q <= hit_d;
      vld_q     <= vld_d;
      quanta_q  <= quanta_d;
      fwd_q     <= ctrl_any && fwd_cfg;
      drop_q    <= ctrl_any && !fwd_cfg;
    end
  end

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> (cat_hit_q == '0) && (vld_q == '0) && !fwd_q && !drop_q);

  p_bad_fcs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !fcs_ok) |=> (cat_hit_q == '0) && (vld_q == '0) && !fwd_q && !drop_q);

  p_fwd_drop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_q && drop_q));

  p_pause_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cat_hit_q[CAT_GPAUSE] || cat_hit_q[CAT_PPAUSE]) |-> (!fwd_q && !drop_q));

  p_global_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q[NUM_PRIO] |-> cat_hit_q[CAT_GPAUSE]);
endmodule

// File: rtl/pause_frame_classifier.sv
module pause_frame_classifier
  import pfc_pkg::*;
#(
  parameter int ADDR_W   = 48,
  parameter int FIELD_W  = 16,
  parameter int NUM_PRIO = 8,
  localparam int NUM_SLOT = NUM_PRIO + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_end,
  input  logic                        fcs_ok,
  input  logic [ADDR_W-1:0]           hdr_da,
  input  logic [ADDR_W-1:0]           hdr_sa,
  input  logic [FIELD_W-1:0]          hdr_etype,
  input  logic [FIELD_W-1:0]          hdr_opcode,
  input  logic [NUM_PRIO-1:0]         hdr_prio_en,
  input  logic [NUM_SLOT*FIELD_W-1:0] hdr_quanta,
  input  logic [ADDR_W-1:0]           cfg_ucast_da,
  input  logic [ADDR_W-1:0]           cfg_mcast_da,
  input  logic [ADDR_W-1:0]           cfg_src_addr,
  input  logic [NUM_CAT-1:0]          cfg_cat_en,
  input  logic [NUM_CAT-1:0]          cfg_chk_mcast,
  input  logic [NUM_CAT-1:0]          cfg_chk_ucast,
  input  logic [NUM_CAT-1:0]          cfg_chk_sa,
  input  logic [NUM_CAT-1:0]          cfg_chk_etype,
  input  logic [NUM_CAT-1:0]          cfg_chk_opcode,
  input  logic [NUM_CAT*FIELD_W-1:0]  cfg_etype,
  input  logic [2*FIELD_W-1:0]        cfg_ctrl_op_min,
  input  logic [2*FIELD_W-1:0]        cfg_ctrl_op_max,
  input  logic [2*FIELD_W-1:0]        cfg_pause_op,
  input  logic                        cfg_fwd_ctrl,
  output logic [NUM_CAT-1:0]          cat_hit,
  output logic [NUM_SLOT-1:0]         pause_vld,
  output logic [NUM_SLOT*FIELD_W-1:0] pause_quanta,
  output logic                        ctrl_fwd,
  output logic                        ctrl_drop
);
  localparam int NUM_CTRL = 2;

  function automatic logic op_in_window(input logic [FIELD_W-1:0] op,
                                        input logic [FIELD_W-1:0] lo,
                                        input logic [FIELD_W-1:0] hi);
    return (op >= lo) && (op <= hi);
  endfunction

  function automatic logic op_exact(input logic [FIELD_W-1:0] op,
                                    input logic [FIELD_W-1:0] want);
    return op == want;
  endfunction

  logic [NUM_CAT-1:0] cat_raw;   // combinational per-category match
  logic [NUM_CAT-1:0] op_ok;     // per-category opcode verdict

  for (genvar k = 0; k < NUM_CAT; k++) begin : g_cat
    cat_chk_t chk;

    assign chk.en     = cfg_cat_en[k];
    assign chk.chk_mc = cfg_chk_mcast[k];
    assign chk.chk_uc = cfg_chk_ucast[k];
    assign chk.chk_sa = cfg_chk_sa[k];
    assign chk.chk_et = cfg_chk_etype[k];

    if (k < NUM_CTRL) begin : g_window
      assign op_ok[k] = !cfg_chk_opcode[k] ||
        op_in_window(hdr_opcode, cfg_ctrl_op_min[k*FIELD_W +: FIELD_W],
                     cfg_ctrl_op_max[k*FIELD_W +: FIELD_W]);
    end else begin : g_exact
      assign op_ok[k] = !cfg_chk_opcode[k] ||
        op_exact(hdr_opcode, cfg_pause_op[(k-NUM_CTRL)*FIELD_W +: FIELD_W]);
    end

    pfc_cat_match #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_match (
      .chk       (chk),
      .da        (hdr_da),
      .sa        (hdr_sa),
      .etype     (hdr_etype),
      .cfg_uc    (cfg_ucast_da),
      .cfg_mc    (cfg_mcast_da),
      .cfg_sa    (cfg_src_addr),
      .cfg_etype (cfg_etype[k*FIELD_W +: FIELD_W]),
      .op_pass   (op_ok[k]),
      .hit       (cat_raw[k])
    );

    p_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_cat_en[k] |=> !cat_hit[k]);
  end

  pfc_out_stage #(.FIELD_W(FIELD_W), .NUM_PRIO(NUM_PRIO)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .fcs_ok    (fcs_ok),
    .hit       (cat_raw),
    .prio_en   (hdr_prio_en),
    .quanta_in (hdr_quanta),
    .fwd_cfg   (cfg_fwd_ctrl),
    .cat_hit_q (cat_hit),
    .vld_q     (pause_vld),
    .quanta_q  (pause_quanta),
    .fwd_q     (ctrl_fwd),
    .drop_q    (ctrl_drop)
  );
endmodule

// File: tb/pause_frame_classifier_tb.sv
module pause_frame_classifier_tb;
  localparam int AW = 48;
  localparam int FW = 16;
  localparam int NP = 8;
  localparam int NS = NP + 1;

  localparam logic [AW-1:0] UC  = 48'h000A_3500_0001;
  localparam logic [AW-1:0] MC  = 48'h0180_C200_0001;
  localparam logic [AW-1:0] SAD = 48'h000A_3511_2233;
  localparam logic [AW-1:0] SAX = 48'h000A_3599_9999;
  localparam logic [AW-1:0] OTH = 48'h0200_0000_BEEF;
  localparam logic [FW-1:0] ET  = 16'h8808;

  typedef struct packed {
    logic [AW-1:0] da;
    logic [AW-1:0] sa;
    logic [FW-1:0] et;
    logic [FW-1:0] op;
    logic [NP-1:0] prio;
    logic          fcs;
    logic [3:0]    e_hit;
    logic [NS-1:0] e_vld;
    logic          e_fwd;
    logic          e_drop;
  } vec_t;

  // fixed config: cat0 mc, op 2..5; cat1 uc+sa, op 0x10..0x20;
  // cat2 uc|mc, op 1; cat3 mc, op 0x101; all etype 0x8808; forward on
  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{MC,  SAX, ET,       16'h0001, 8'h00, 1'b1, 4'b0100, 9'h100, 1'b0, 1'b0}, // R8 R2 mc
    '{UC,  SAX, ET,       16'h0001, 8'h00, 1'b1, 4'b0100, 9'h100, 1'b0, 1'b0}, // R2 uc via both
    '{MC,  SAX, ET,       16'h0101, 8'hA5, 1'b1, 4'b1000, 9'h0A5, 1'b0, 1'b0}, // R7 R6
    '{MC,  SAX, ET,       16'h0003, 8'h00, 1'b1, 4'b0001, 9'h000, 1'b1, 1'b0}, // R5 R9
    '{MC,  SAX, ET,       16'h0005, 8'h00, 1'b1, 4'b0001, 9'h000, 1'b1, 1'b0}, // R5 max
    '{MC,  SAX, ET,       16'h0006, 8'h00, 1'b1, 4'b0000, 9'h000, 1'b0, 1'b0}, // R5 above
    '{UC,  SAD, ET,       16'h0010, 8'h00, 1'b1, 4'b0010, 9'h000, 1'b1, 1'b0}, // R5 min R3
    '{UC,  SAX, ET,       16'h0010, 8'h00, 1'b1, 4'b0000, 9'h000, 1'b0, 1'b0}, // R3 bad sa
    '{MC,  SAX, 16'h0800, 16'h0001, 8'h00, 1'b1, 4'b0000, 9'h000, 1'b0, 1'b0}, // R4
    '{OTH, SAX, ET,       16'h0001, 8'h00, 1'b1, 4'b0000, 9'h000, 1'b0, 1'b0}, // R2 no addr
    '{MC,  SAX, ET,       16'h0001, 8'h00, 1'b0, 4'b0000, 9'h000, 1'b0, 1'b0}  // R10
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_end = 1'b0, fcs_ok = 1'b0;
  logic [AW-1:0] hdr_da = '0, hdr_sa = '0;
  logic [FW-1:0] hdr_etype = '0, hdr_opcode = '0;
  logic [NP-1:0] hdr_prio_en = '0;
  logic [NS*FW-1:0] hdr_quanta = '0;
  logic [AW-1:0] cfg_ucast_da, cfg_mcast_da, cfg_src_addr;
  logic [3:0] cfg_cat_en, cfg_chk_mcast, cfg_chk_ucast, cfg_chk_sa, cfg_chk_etype, cfg_chk_opcode;
  logic [4*FW-1:0] cfg_etype;
  logic [2*FW-1:0] cfg_ctrl_op_min, cfg_ctrl_op_max, cfg_pause_op;
  logic cfg_fwd_ctrl;
  logic [3:0] cat_hit;
  logic [NS-1:0] pause_vld;
  logic [NS*FW-1:0] pause_quanta;
  logic ctrl_fwd, ctrl_drop;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pause_frame_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .fcs_ok(fcs_ok),
    .hdr_da(hdr_da), .hdr_sa(hdr_sa), .hdr_etype(hdr_etype), .hdr_opcode(hdr_opcode),
    .hdr_prio_en(hdr_prio_en), .hdr_quanta(hdr_quanta),
    .cfg_ucast_da(cfg_ucast_da), .cfg_mcast_da(cfg_mcast_da), .cfg_src_addr(cfg_src_addr),
    .cfg_cat_en(cfg_cat_en), .cfg_chk_mcast(cfg_chk_mcast), .cfg_chk_ucast(cfg_chk_ucast),
    .cfg_chk_sa(cfg_chk_sa), .cfg_chk_etype(cfg_chk_etype), .cfg_chk_opcode(cfg_chk_opcode),
    .cfg_etype(cfg_etype), .cfg_ctrl_op_min(cfg_ctrl_op_min), .cfg_ctrl_op_max(cfg_ctrl_op_max),
    .cfg_pause_op(cfg_pause_op), .cfg_fwd_ctrl(cfg_fwd_ctrl),
    .cat_hit(cat_hit), .pause_vld(pause_vld), .pause_quanta(pause_quanta),
    .ctrl_fwd(ctrl_fwd), .ctrl_drop(ctrl_drop)
  );

  task automatic cfg_default();
    cfg_ucast_da    = UC;
    cfg_mcast_da    = MC;
    cfg_src_addr    = SAD;
    cfg_cat_en      = 4'b1111;
    cfg_chk_mcast   = 4'b1101;
    cfg_chk_ucast   = 4'b0110;
    cfg_chk_sa      = 4'b0010;
    cfg_chk_etype   = 4'b1111;
    cfg_chk_opcode  = 4'b1111;
    cfg_etype       = {4{ET}};
    cfg_ctrl_op_min = {16'h0010, 16'h0002};
    cfg_ctrl_op_max = {16'h0020, 16'h0005};
    cfg_pause_op    = {16'h0101, 16'h0001};
    cfg_fwd_ctrl    = 1'b1;
  endtask

  // input quanta slot i = {tag, i}
  function automatic logic [NS*FW-1:0] mk_quanta(input logic [7:0] tag);
    logic [NS*FW-1:0] q;
    for (int i = 0; i < NS; i++) q[i*FW +: FW] = {tag, 8'(i)};
    return q;
  endfunction

  function automatic logic [NS*FW-1:0] exp_quanta(input logic [NS-1:0] v, input logic [7:0] tag);
    logic [NS*FW-1:0] q;
    for (int i = 0; i < NS; i++) q[i*FW +: FW] = v[i] ? {tag, 8'(i)} : 16'h0;
    return q;
  endfunction

  task automatic check(input string req, input logic [3:0] eh, input logic [NS-1:0] ev,
                       input logic ef, input logic ed, input logic [7:0] tag);
    logic [NS*FW-1:0] eq;
    eq = exp_quanta(ev, tag);
    n_chk++;
    if (cat_hit !== eh || pause_vld !== ev || ctrl_fwd !== ef || ctrl_drop !== ed ||
        pause_quanta !== eq) begin
      n_fail++;
      $display("FAIL %s: hit=%b vld=%h fwd=%b drop=%b q=%h | exp hit=%b vld=%h fwd=%b drop=%b q=%h",
               req, cat_hit, pause_vld, ctrl_fwd, ctrl_drop, pause_quanta,
               eh, ev, ef, ed, eq);
    end
  endtask

  // drive one frame at a falling edge; result is visible at the next falling edge
  task automatic send(input logic [AW-1:0] da, input logic [AW-1:0] sa, input logic [FW-1:0] et,
                      input logic [FW-1:0] op, input logic [NP-1:0] pe, input logic fcs,
                      input logic [7:0] tag);
    @(negedge clk);
    hdr_da = da; hdr_sa = sa; hdr_etype = et; hdr_opcode = op;
    hdr_prio_en = pe; hdr_quanta = mk_quanta(tag); fcs_ok = fcs; frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_default();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R13 in reset", 4'b0, '0, 1'b0, 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R13 after reset", 4'b0, '0, 1'b0, 1'b0, 8'h00);

    // table walk
    for (int v = 0; v < NV; v++) begin
      send(TBL[v].da, TBL[v].sa, TBL[v].et, TBL[v].op, TBL[v].prio, TBL[v].fcs, 8'(v + 8'h10));
      check($sformatf("R2-table vec %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10)", v),
            TBL[v].e_hit, TBL[v].e_vld, TBL[v].e_fwd, TBL[v].e_drop, 8'(v + 8'h10));
    end

    // R11: pulse lasts one cycle
    send(MC, SAX, ET, 16'h0101, 8'hFF, 1'b1, 8'h33);
    check("R7 all priorities", 4'b1000, 9'h0FF, 1'b0, 1'b0, 8'h33);
    @(negedge clk);
    check("R11 pulse cleared", 4'b0, '0, 1'b0, 1'b0, 8'h00);

    // R11: matching header without strobe gives nothing
    hdr_da = MC; hdr_etype = ET; hdr_opcode = 16'h0001; fcs_ok = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R11 no strobe", 4'b0, '0, 1'b0, 1'b0, 8'h00);

    // R1: disabled global pause category
    cfg_cat_en = 4'b1011;
    send(MC, SAX, ET, 16'h0001, 8'h00, 1'b1, 8'h40);
    check("R1 disabled category", 4'b0, '0, 1'b0, 1'b0, 8'h40);
    cfg_cat_en = 4'b1111;

    // R9: drop mode
    cfg_fwd_ctrl = 1'b0;
    send(MC, SAX, ET, 16'h0004, 8'h00, 1'b1, 8'h41);
    check("R9 drop control", 4'b0001, '0, 1'b0, 1'b1, 8'h41);
    cfg_fwd_ctrl = 1'b1;

    // R2: no address check on priority pause -> any DA
    cfg_chk_mcast[3] = 1'b0;
    send(OTH, SAX, ET, 16'h0101, 8'h03, 1'b1, 8'h42);
    check("R2 no DA check", 4'b1000, 9'h003, 1'b0, 1'b0, 8'h42);
    cfg_chk_mcast[3] = 1'b1;

    // R12: overlap of control window and global pause opcode
    cfg_ctrl_op_min[FW-1:0] = 16'h0000;
    send(MC, SAX, ET, 16'h0001, 8'h00, 1'b1, 8'h43);
    check("R12 pause over control", 4'b0101, 9'h100, 1'b0, 1'b0, 8'h43);

    // R10: bad FCS on a control frame
    send(MC, SAX, ET, 16'h0003, 8'h00, 1'b0, 8'h44);
    check("R10 bad fcs control", 4'b0, '0, 1'b0, 1'b0, 8'h44);

    // R6: opcode check off on global pause -> any opcode
    cfg_default();
    cfg_chk_opcode[2] = 1'b0;
    send(UC, SAX, ET, 16'h7777, 8'h00, 1'b1, 8'h45);
    check("R6 opcode check off", 4'b0100, 9'h100, 1'b0, 1'b0, 8'h45);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule